// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is the receive side of a 7-bit-addressed I2C target. It watches SCL and SDA through synchronizer flops and finds start and stop conditions. After each start it compares the first byte against a programmed own address. When that byte matches, the block acknowledges it and every later byte until the next start or stop, and hands each byte to the host.

Received bytes leave on a valid/ready stream. `rx_valid` is the receive-full flag. A byte is taken when `rx_valid` and `rx_ready` are both high on a clock edge. Back-pressure reaches the bus: if the host has not taken the previous byte by the time the eighth SCL pulse of the next byte falls, the block holds SCL low. It releases SCL on the cycle after the host takes the byte.

The matched address byte, with its R/W bit, is delivered as the first stream byte. The host discards it. The acknowledge level is set by `cfg_ack_nack`. The block captures that level when each byte begins, so a change made while a byte is pending applies to the byte after the one in flight.

Top module: `i2c_slave_rx`

## Requirements
- R1: While `cfg_enable` is 0 or `cfg_slave_rx` is 0, the block never pulls SCL or SDA low, never raises `rx_valid` and never sets `stop_seen`. It releases both lines on the cycle after either bit drops.
- R2: A start condition is SDA falling while SCL is high. The first byte after it is compared with `cfg_own_addr`. Its upper 7 bits must equal the address and its least significant bit (R/W) must be 0 for a match.
- R3: After a match, the block drives SDA during the ninth SCL pulse. It pulls SDA low when the captured level is 0 (ACK) and leaves SDA released when the level is 1 (NACK). It starts driving SDA only while SCL is low.
- R4: At the rising edge of the ninth clock of a matching address byte, `rx_valid` rises and `rx_data` holds the full address byte, including the R/W bit.
- R5: Each data byte after a match arrives MSB first, on clocks 1 to 8. At the ninth rising edge it is presented on `rx_data` with `rx_valid` set, and it is acknowledged at the captured level.
- R6: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` stays unchanged. A cycle with both high clears `rx_valid`.
- R7: If `rx_valid` is still 1 when the eighth SCL pulse of a byte falls, the block holds SCL low until the host takes the byte, and releases SCL in the cycle after. The block holds SCL low only while `rx_valid` is 1.
- R8: The acknowledge level is captured from `cfg_ack_nack` at the first SCL rising edge of each byte. A change made while a byte is pending, including during a stretch, affects the next byte's acknowledge and not the current one.
- R9: On an address mismatch the block gives no acknowledge, delivers no byte and never stretches. It ignores all bytes until the next start, and a repeated start is matched again.
- R10: A stop condition is SDA rising while SCL is high. It returns the block to waiting for a start, releases both lines and sets `stop_seen`. A one-cycle `stop_clr` pulse clears `stop_seen`, and a stop detected in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Block enable |
| cfg_slave_rx | input | 1 | Mode select; 1 selects slave receive |
| cfg_own_addr | input | ADDR_W | 7-bit own address |
| cfg_ack_nack | input | 1 | Acknowledge level: 0 gives ACK, 1 gives NACK |
| scl_i | input | 1 | SCL level sampled from the pad |
| sda_i | input | 1 | SDA level sampled from the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low (stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_valid | output | 1 | Receive-full flag, stream valid |
| rx_ready | input | 1 | Host takes the byte when high with `rx_valid` |
| rx_data | output | ADDR_W+1 | Received byte |
| stop_seen | output | 1 | Sticky stop-detected flag |
| stop_clr | input | 1 | Clears `stop_seen` |

## Verification
The bench stretches SCL by leaving a byte unread until the next byte's eighth clock falls. A design that stretched at the wrong time or never released SCL would hang the bus model or shift the received bits. While SCL is held low, the bench changes the acknowledge level. A design that applied the change at once would NACK the byte in flight instead of the following one. Address bytes with the wrong address bits or with R/W set to 1 must be NACKed and produce no stream bytes. A repeated start must re-arm address matching, or a later matching address would be lost. A design that acted while disabled or in the wrong mode would pull SDA low on the bus.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } srx_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } srx_evt_t;

endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync
  import i2c_srx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     sda_s,
  output srx_evt_t evt
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] line_p;

  assign line_in = {sda_i, scl_i};

  // one flop chain per bus line, idle level high
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
      end else begin
        chain <= {chain[STAGES-2:0], line_in[g]};
      end
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p <= '1;
    end else begin
      line_p <= line_s;
    end
  end

  logic scl_now, scl_was, sda_now, sda_was;
  assign scl_now = line_s[0];
  assign scl_was = line_p[0];
  assign sda_now = line_s[1];
  assign sda_was = line_p[1];

  assign sda_s        = sda_now;
  assign evt.scl_rise = scl_now & ~scl_was;
  assign evt.scl_fall = ~scl_now & scl_was;
  assign evt.start    = scl_now & scl_was & sda_was & ~sda_now;
  assign evt.stop     = scl_now & scl_was & ~sda_was & sda_now;

endmodule

// File: rtl/i2c_srx_rxbuf.sv
module i2c_srx_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  // a load arriving while full and not being taken is dropped so the
  // pending byte never changes under the host
  logic accept;
  assign accept = load & (~full | take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) begin
        full <= 1'b0;
      end
      if (accept) begin
        full <= 1'b1;
        data <= load_data;
      end
    end
  end

endmodule

// File: rtl/i2c_srx_ctrl.sv
module i2c_srx_ctrl
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_cfg,
  input  srx_evt_t          evt,
  input  logic              sda_s,
  input  logic              rx_full,
  input  logic              rd_take,
  output logic              load,
  output logic [ADDR_W:0]   load_data,
  output logic              scl_low,
  output logic              sda_low,
  output logic              stop_pulse
);

  localparam int DATA_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACKC = CNT_W'(DATA_W + 1);

  srx_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              ack_lvl;
  logic              frame_ack;
  logic              addr_hit;
  logic              take_frame;

  assign addr_hit   = (shreg[DATA_W-1:1] == own_addr) && !shreg[0];
  assign take_frame = (state == ST_DATA) || ((state == ST_ADDR) && addr_hit);
  assign load_data  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      ack_lvl    <= 1'b0;
      frame_ack  <= 1'b0;
      sda_low    <= 1'b0;
      scl_low    <= 1'b0;
      load       <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      load       <= 1'b0;
      stop_pulse <= 1'b0;
      if (!active) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        frame_ack <= 1'b0;
        sda_low   <= 1'b0;
        scl_low   <= 1'b0;
      end else if (evt.stop) begin
        state      <= ST_IDLE;
        cnt        <= '0;
        frame_ack  <= 1'b0;
        sda_low    <= 1'b0;
        scl_low    <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (evt.start) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        frame_ack <= 1'b0;
        sda_low   <= 1'b0;
        scl_low   <= 1'b0;
      end else if (state != ST_IDLE) begin
        // end of stretch once the pending byte is gone
        if (scl_low && (!rx_full || rd_take)) begin
          scl_low <= 1'b0;
        end
        if (evt.scl_rise) begin
          if (cnt < LAST) begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
            if (cnt == '0) begin
              ack_lvl <= ack_cfg;
            end
          end else if (cnt == LAST) begin
            cnt  <= ACKC;
            load <= frame_ack;
          end
        end
        if (evt.scl_fall) begin
          if (cnt == LAST) begin
            if (take_frame) begin
              frame_ack <= 1'b1;
              sda_low   <= !ack_lvl;
              scl_low   <= rx_full && !rd_take;
            end else begin
              frame_ack <= 1'b0;
            end
          end else if (cnt == ACKC) begin
            cnt     <= '0;
            sda_low <= 1'b0;
            if (state == ST_ADDR) begin
              state <= frame_ack ? ST_DATA : ST_SKIP;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_slave_rx,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_ack_nack,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [ADDR_W:0]   rx_data,
  output logic              stop_seen,
  input  logic              stop_clr
);

  localparam int DATA_W = ADDR_W + 1;

  srx_evt_t          evt;
  logic              sda_s;
  logic              active;
  logic              take;
  logic              load;
  logic [DATA_W-1:0] load_data;
  logic              stop_pulse;

  assign active = cfg_enable & cfg_slave_rx;
  assign take   = rx_valid & rx_ready;

  i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .sda_s (sda_s),
    .evt   (evt)
  );

  i2c_srx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .own_addr   (cfg_own_addr),
    .ack_cfg    (cfg_ack_nack),
    .evt        (evt),
    .sda_s      (sda_s),
    .rx_full    (rx_valid),
    .rd_take    (take),
    .load       (load),
    .load_data  (load_data),
    .scl_low    (scl_drive_low),
    .sda_low    (sda_drive_low),
    .stop_pulse (stop_pulse)
  );

  i2c_srx_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .take      (take),
    .full      (rx_valid),
    .data      (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_seen <= 1'b0;
    end else if (stop_pulse) begin
      stop_seen <= 1'b1;
    end else if (stop_clr) begin
      stop_seen <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_enable,
  input logic            cfg_slave_rx,
  input logic            scl_i,
  input logic            scl_drive_low,
  input logic            sda_drive_low,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [ADDR_W:0] rx_data,
  input logic            stop_seen
);

  p_release_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_enable && cfg_slave_rx) |=> (!scl_drive_low && !sda_drive_low));

  p_ack_in_low_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_i);

  p_hold_until_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_stretch_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> rx_valid);

  p_release_on_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !scl_drive_low);

  p_stop_only_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> $past(cfg_enable && cfg_slave_rx, 2));

endmodule

bind i2c_slave_rx i2c_srx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_slave_rx  (cfg_slave_rx),
  .scl_i         (scl_i),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .rx_valid      (rx_valid),
  .rx_ready      (rx_ready),
  .rx_data       (rx_data),
  .stop_seen     (stop_seen)
);

// File: tb/i2c_slave_rx_tb.sv
`timescale 1ns/1ps
module i2c_slave_rx_tb;

  localparam logic [6:0] OWN = 7'h52;
  localparam int NVEC = 6;
  // {ack_cfg, addr byte, data byte, exp addr ack bit, exp data ack bit, delivered}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 8'hA4, 8'h3C, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'hA6, 8'h3C, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'hA5, 8'h77, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'hA4, 8'hC3, 1'b1, 1'b1, 1'b1},
    {1'b0, 8'hA4, 8'h81, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h24, 8'hFF, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_slave_rx = 1'b0, cfg_ack_nack = 1'b0;
  logic rx_ready = 1'b0, stop_clr = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_drive_low, sda_drive_low, rx_valid, stop_seen;
  logic [7:0] rx_data;
  wire scl_bus = m_scl & ~scl_drive_low;
  wire sda_bus = m_sda & ~sda_drive_low;

  int checks = 0, errors = 0;
  bit host_auto = 1'b0;
  logic [7:0] cap [4];
  int cap_cnt = 0;

  always #2 clk = ~clk;

  i2c_slave_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_slave_rx(cfg_slave_rx),
    .cfg_own_addr(OWN), .cfg_ack_nack(cfg_ack_nack), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .stop_seen(stop_seen), .stop_clr(stop_clr)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // auto host: takes every byte one cycle after it appears
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (host_auto && rx_valid && !rx_ready) begin
        if (cap_cnt < 4) cap[cap_cnt] = rx_data;
        cap_cnt++;
        rx_ready = 1'b1;
      end else if (host_auto) begin
        rx_ready = 1'b0;
      end
    end
  end

  task automatic host_take(output logic [7:0] d);
    while (!rx_valid) tick(1);
    d = rx_data;
    rx_ready = 1'b1;
    tick(1);
    rx_ready = 1'b0;
  endtask

  task automatic pulse(output logic bit_seen);
    m_scl = 1'b1;
    while (!scl_bus) tick(1);
    tick(10);
    bit_seen = sda_bus;
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic dummy;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      tick(6);
      pulse(dummy);
    end
    m_sda = 1'b1;
    tick(6);
    pulse(ack);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1;
    tick(10);
    m_sda = 1'b0;
    tick(10);
    m_scl = 1'b0;
  endtask

  task automatic m_restart();
    m_sda = 1'b1;
    tick(6);
    m_scl = 1'b1;
    tick(10);
    m_sda = 1'b0;
    tick(10);
    m_scl = 1'b0;
  endtask

  task automatic m_stop();
    m_sda = 1'b0;
    tick(6);
    m_scl = 1'b1;
    tick(10);
    m_sda = 1'b1;
    tick(10);
  endtask

  initial begin
    tick(150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // reset state
    chk(!scl_drive_low && !sda_drive_low, "R1 reset lines", {scl_drive_low, sda_drive_low}, 0);
    chk(!rx_valid, "R1 reset rx_valid", rx_valid, 0);
    chk(!stop_seen, "R10 reset stop_seen", stop_seen, 0);

    // R1: disabled, then enabled in wrong mode
    for (int m = 0; m < 2; m++) begin
      cfg_enable = (m == 1);
      cfg_slave_rx = 1'b0;
      m_start();
      send_byte(8'hA4, a0);
      chk(a0 == 1'b1, "R1 no ack when inactive", a0, 1);
      chk(!rx_valid, "R1 no byte when inactive", rx_valid, 0);
      m_stop();
      chk(!stop_seen, "R1 no stop flag when inactive", stop_seen, 0);
    end
    cfg_enable = 1'b1;
    cfg_slave_rx = 1'b1;
    tick(4);

    // table: R2 R3 R4 R5 R9
    host_auto = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      cap_cnt = 0;
      cfg_ack_nack = VEC[v][19];
      m_start();
      send_byte(VEC[v][18:11], a0);
      chk(a0 == VEC[v][2], "R2 R3 address ack bit", a0, VEC[v][2]);
      send_byte(VEC[v][10:3], a1);
      chk(a1 == VEC[v][1], "R5 R9 data ack bit", a1, VEC[v][1]);
      m_stop();
      tick(4);
      chk(cap_cnt == (VEC[v][0] ? 2 : 0), "R9 R5 bytes delivered", cap_cnt, VEC[v][0] ? 2 : 0);
      if (VEC[v][0]) begin
        chk(cap[0] == VEC[v][18:11], "R4 dummy address byte", cap[0], VEC[v][18:11]);
        chk(cap[1] == VEC[v][10:3], "R5 data byte", cap[1], VEC[v][10:3]);
      end
      chk(stop_seen, "R10 stop flag set", stop_seen, 1);
      stop_clr = 1'b1;
      tick(1);
      stop_clr = 1'b0;
      tick(1);
      chk(!stop_seen, "R10 stop flag cleared", stop_seen, 0);
    end
    host_auto = 1'b0;
    rx_ready = 1'b0;
    cfg_ack_nack = 1'b0;

    // R7 stretch and R8 ack level timing
    m_start();
    send_byte(8'hA4, a0);
    chk(a0 == 1'b0, "R3 address acked", a0, 0);
    host_take(d);
    chk(d == 8'hA4, "R4 dummy read value", d, 8'hA4);
    send_byte(8'h5A, a1);
    chk(a1 == 1'b0, "R5 first data acked", a1, 0);
    fork
      send_byte(8'h96, a2);
      begin
        while (!scl_drive_low) tick(1);
        tick(30);
        chk(scl_drive_low, "R7 SCL held while full", scl_drive_low, 1);
        chk(rx_data == 8'h5A, "R6 pending byte stable", rx_data, 8'h5A);
        cfg_ack_nack = 1'b1;
        host_take(d);
        chk(d == 8'h5A, "R7 pending byte value", d, 8'h5A);
        chk(!scl_drive_low, "R7 SCL released after take", scl_drive_low, 0);
      end
    join
    chk(a2 == 1'b0, "R8 current byte keeps old level", a2, 0);
    host_take(d);
    chk(d == 8'h96, "R7 stretched byte intact", d, 8'h96);
    send_byte(8'h11, a3);
    chk(a3 == 1'b1, "R8 next byte uses new level", a3, 1);
    host_take(d);
    chk(d == 8'h11, "R5 byte after nack level", d, 8'h11);
    m_stop();
    cfg_ack_nack = 1'b0;
    stop_clr = 1'b1;
    tick(1);
    stop_clr = 1'b0;

    // R9 mismatch then repeated start
    host_auto = 1'b1;
    cap_cnt = 0;
    m_start();
    send_byte(8'hA6, a0);
    chk(a0 == 1'b1, "R9 mismatch nack", a0, 1);
    send_byte(8'h55, a1);
    chk(a1 == 1'b1, "R9 ignored byte nack", a1, 1);
    chk(cap_cnt == 0 && !scl_drive_low, "R9 nothing delivered", cap_cnt, 0);
    m_restart();
    send_byte(8'hA4, a2);
    chk(a2 == 1'b0, "R9 repeated start rematch", a2, 0);
    send_byte(8'h66, a3);
    chk(a3 == 1'b0, "R9 data after rematch acked", a3, 0);
    m_stop();
    tick(4);
    chk(cap_cnt == 2 && cap[1] == 8'h66, "R9 byte after rematch", cap[1], 8'h66);
    chk(stop_seen && !scl_drive_low && !sda_drive_low, "R10 stop releases lines",
        {stop_seen, scl_drive_low, sda_drive_low}, 3'b100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule